// File: doc/BRIEF.md
# Indexed Device Register Port with Interrupt Status

This block is the control front end of a display-style device, reached through a small window of byte offsets on a single-cycle read/write bus. Software first writes a register number into an index port. It then reads or writes that register through a value port. A third port, at its own offset, shows the latched interrupt sources and clears them. Behind the index sit an identification register, an enable register, three mode registers, a read-only capability word, an interrupt mask, a colour table starting at a high index, and a few scratch words placed directly after the colour table.

The identification register supports version negotiation. The driver writes the identifier of the version it wants. The block keeps that identifier only if it names a version the block supports. Otherwise the register reads back the highest supported identifier, and the driver steps downward from there. Every identifier is the constant 0x900000 shifted left by 8 bits, with the version number in the low byte.

Three event strobes from the rest of the device set sticky status bits. A level interrupt is raised while any set status bit is also enabled in the mask. Interrupt support exists only when the capability word advertises it.

Top module: `idxreg_front`

## Requirements
- R1: After reset, the following hold: the index is 0, the enable field is 0, both mask and status are 0, `irq` is low, and the identification register holds the highest supported identifier (0x90000000 | MAX_VER).
- R2: Bus offset 0 is the index port and offset 1 is the value port. Offset 8 is the interrupt status port, which reads the status in bits 2:0. Every other offset reads 0, and writes to it change nothing.
- R3: The index keeps its value across any number of value-port accesses and never advances by itself.
- R4: A write to index 0 stores the value only when bits 31:8 equal 0x900000 and bits 7:0 are at most MAX_VER. Any other value, including 0xFFFFFFFF, leaves the register at 0x90000000 | MAX_VER.
- R5: Index 1 is the enable register. Bit 0 drives `cfg_enable` and bit 1 drives `cfg_hide`. It reads back those two bits with zeros above them, and writing 0 clears both.
- R6: Indices 2, 3 and 7 hold 32-bit width, height and bits-per-pixel values, which drive `mode_width`, `mode_height` and `mode_bpp`.
- R7: Index 17 reads the CAPS parameter, and writes to it are ignored. Index 33 is the 3-bit interrupt mask. When CAPS bit 18 (0x00040000) is clear, the mask reads 0 and cannot be written.
- R8: Indices PAL_BASE to PAL_BASE+PAL_N-1 form the colour table. Each entry stores the low 8 bits of a write and reads them back zero-extended.
- R9: The SCR_N indices that start at PAL_BASE+PAL_N are 32-bit scratch words.
- R10: Any index that is not implemented reads 0 through the value port, and writes to it are ignored.
- R11: Status bit 0 is set by `evt[0]` (a fence passed), bit 1 by `evt[1]` (queue progress) and bit 2 by `evt[2]` (fence goal reached). Writing a 1 to a status bit through offset 8 clears it. An event in the same cycle as a clear wins, and a bit set by an event stays set until it is cleared.
- R12: `irq` equals the OR of (status AND mask) when CAPS bit 18 is set, and is always low when that bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| evt | input | 3 | Event strobes: fence, progress, goal |
| cfg_enable | output | 1 | Device enabled |
| cfg_hide | output | 1 | Device hidden |
| mode_width | output | 32 | Width register |
| mode_height | output | 32 | Height register |
| mode_bpp | output | 32 | Bits-per-pixel register |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two instances that share one bus.

The first instance uses the defaults: MAX_VER=2, a capability word that advertises interrupts, a 768-entry colour table at index 1024, and 4 scratch words. This instance makes every interrupt path and all three identifier versions reachable. The random stimulus also covers the colour table's first and last entries and the scratch words on each side of the table's end.

The second instance uses MAX_VER=1 and a capability word without the interrupt bit. It brings within reach the rejection of a version that the first instance accepts, a mask that ignores writes, and an interrupt that never rises.

// File: rtl/idxreg_front.sv
module idxreg_front #(
  parameter int          MAX_VER  = 2,
  parameter logic [31:0] CAPS     = 32'h0004_8002,
  parameter int          PAL_BASE = 1024,
  parameter int          PAL_N    = 768,
  parameter int          SCR_N    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [2:0]  evt,
  output logic        cfg_enable,
  output logic        cfg_hide,
  output logic [31:0] mode_width,
  output logic [31:0] mode_height,
  output logic [31:0] mode_bpp,
  output logic        irq
);
  localparam logic [31:0] ID_TOP   = (32'h0090_0000 << 8) | 32'(MAX_VER);
  localparam int          SCR_BASE = PAL_BASE + PAL_N;
  localparam int          PW       = $clog2(PAL_N);
  localparam int          SW       = $clog2(SCR_N);
  localparam bit          IRQ_ON   = CAPS[18];

  logic [31:0] index_q, id_q, scr_q [SCR_N];
  logic [7:0]  pal_q [PAL_N];
  logic [1:0]  en_q;
  logic [2:0]  mask_q, status_q;
  logic [31:0] val_rd;

  wire wr      = bus_sel && bus_we;
  wire wr_idx  = wr && bus_addr == 4'd0;
  wire wr_val  = wr && bus_addr == 4'd1;
  wire wr_stat = wr && bus_addr == 4'd8;
  wire pal_hit = index_q >= 32'(PAL_BASE) && index_q < 32'(SCR_BASE);
  wire scr_hit = index_q >= 32'(SCR_BASE) && index_q < 32'(SCR_BASE + SCR_N);
  wire [PW-1:0] pal_a = PW'(index_q - 32'(PAL_BASE));
  wire [SW-1:0] scr_a = SW'(index_q - 32'(SCR_BASE));
  wire id_ok = bus_wdata[31:8] == 24'h90_0000 && bus_wdata[7:0] <= 8'(MAX_VER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q     <= '0;
      id_q        <= ID_TOP;
      en_q        <= '0;
      mode_width  <= '0;
      mode_height <= '0;
      mode_bpp    <= '0;
      mask_q      <= '0;
      status_q    <= '0;
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
      for (int i = 0; i < SCR_N; i++) scr_q[i] <= '0;
    end else begin
      if (wr_idx) index_q <= bus_wdata;
      status_q <= (status_q & ~(wr_stat ? bus_wdata[2:0] : 3'b000)) | evt;
      if (wr_val) begin
        case (index_q)
          32'd0:  id_q        <= id_ok ? bus_wdata : ID_TOP;
          32'd1:  en_q        <= bus_wdata[1:0];
          32'd2:  mode_width  <= bus_wdata;
          32'd3:  mode_height <= bus_wdata;
          32'd7:  mode_bpp    <= bus_wdata;
          32'd33: if (IRQ_ON) mask_q <= bus_wdata[2:0];
          default: begin
            if (pal_hit) pal_q[pal_a] <= bus_wdata[7:0];
            if (scr_hit) scr_q[scr_a] <= bus_wdata;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (index_q)
      32'd0:  val_rd = id_q;
      32'd1:  val_rd = {30'd0, en_q};
      32'd2:  val_rd = mode_width;
      32'd3:  val_rd = mode_height;
      32'd7:  val_rd = mode_bpp;
      32'd17: val_rd = CAPS;
      32'd33: val_rd = {29'd0, mask_q};
      default: val_rd = pal_hit ? {24'd0, pal_q[pal_a]} :
                        scr_hit ? scr_q[scr_a] : 32'd0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we)
      case (bus_addr)
        4'd0:    bus_rdata = index_q;
        4'd1:    bus_rdata = val_rd;
        4'd8:    bus_rdata = {29'd0, status_q};
        default: bus_rdata = '0;
      endcase
  end

  assign cfg_enable = en_q[0];
  assign cfg_hide   = en_q[1];
  assign irq        = IRQ_ON && |(status_q & mask_q);
endmodule

// File: rtl/idxreg_front_chk.sv
module idxreg_front_chk #(
  parameter int MAX_VER = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [2:0]  evt,
  input logic        irq,
  input logic [31:0] index_q,
  input logic [31:0] id_q,
  input logic [2:0]  mask_q,
  input logic [2:0]  status_q
);
  a_r4_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[31:8] == 24'h90_0000 && id_q[7:0] <= 8'(MAX_VER));

  a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == 4'd0) |=> $stable(index_q));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 4'd8 && bus_wdata[0] && !evt[0]) |=> !status_q[0]);

  a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> status_q[1]);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status_q) & ~status_q)) |-> $past(bus_sel && bus_we && bus_addr == 4'd8));

  a_r12_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|mask_q) && (|status_q));
endmodule

bind idxreg_front idxreg_front_chk #(.MAX_VER(MAX_VER)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt), .irq(irq),
  .index_q(index_q), .id_q(id_q), .mask_q(mask_q), .status_q(status_q));

// File: tb/idxreg_front_bench.sv
`timescale 1ns/1ps
module idxreg_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rd1, rd2;
  logic [2:0] evt = '0;
  logic en1, hd1, en2, hd2, irq1, irq2;
  logic [31:0] w1, h1, b1, w2, h2, b2;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idxreg_front u_idxreg_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .evt(evt), .cfg_enable(en1), .cfg_hide(hd1),
    .mode_width(w1), .mode_height(h1), .mode_bpp(b1), .irq(irq1));

  idxreg_front #(.MAX_VER(1), .CAPS(32'h0000_8002)) u_nocap (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd2), .evt(evt), .cfg_enable(en2), .cfg_hide(hd2),
    .mode_width(w2), .mode_height(h2), .mode_bpp(b2), .irq(irq2));

  // model of the default instance
  logic [31:0] m_id = 32'h9000_0002, m_w = 0, m_h = 0, m_b = 0;
  logic [1:0]  m_en = 0;
  logic [2:0]  m_mask = 0;
  logic [7:0]  pal_m [768];
  logic [31:0] scr_m [4];

  function automatic logic [31:0] exp_id(logic [31:0] d, int maxv);
    if (d[31:8] == 24'h90_0000 && int'(d[7:0]) <= maxv) return d;
    return 32'h9000_0000 | 32'(maxv);
  endfunction

  function automatic logic [31:0] model_rd(int idx);
    case (idx)
      0: return m_id;
      1: return {30'd0, m_en};
      2: return m_w;
      3: return m_h;
      7: return m_b;
      17: return 32'h0004_8002;
      33: return {29'd0, m_mask};
      default:
        if (idx >= 1024 && idx < 1792) return {24'd0, pal_m[idx-1024]};
        else if (idx >= 1792 && idx < 1796) return scr_m[idx-1792];
        else return 32'd0;
    endcase
  endfunction

  task automatic model_wr(int idx, logic [31:0] d);
    case (idx)
      0: m_id = exp_id(d, 2);
      1: m_en = d[1:0];
      2: m_w = d;
      3: m_h = d;
      7: m_b = d;
      33: m_mask = d[2:0];
      default: begin
        if (idx >= 1024 && idx < 1792) pal_m[idx-1024] = d[7:0];
        if (idx >= 1792 && idx < 1796) scr_m[idx-1792] = d;
      end
    endcase
  endtask

  function automatic int pick_idx(int r);
    case (r % 14)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 7;   5: return 17;  6: return 33;  7: return 40;
      8: return 1024; 9: return 1791; 10: return 1024 + int'($urandom_range(767));
      11: return 1792 + int'($urandom_range(3)); 12: return 1796;
      default: return 5000;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [3:0] a, logic [31:0] d, logic [2:0] e = 3'b000);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; evt = e;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; evt = 0;
  endtask

  task automatic brd(logic [3:0] a, output logic [31:0] d1, output logic [31:0] d2);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    d1 = rd1; d2 = rd2;
    bus_sel = 0;
  endtask

  task automatic pulse(logic [2:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  initial begin
    logic [31:0] a, b;
    for (int i = 0; i < 768; i++) pal_m[i] = 0;
    for (int i = 0; i < 4; i++) scr_m[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    brd(4'd0, a, b); chk("R1 index", a, 0);
    brd(4'd1, a, b); chk("R1 id", a, 32'h9000_0002); chk("R1 id nocap", b, 32'h9000_0001);
    brd(4'd8, a, b); chk("R1 status", a, 0);
    chk("R1 irq", {31'd0, irq1}, 0); chk("R1 enable", {30'd0, hd1, en1}, 0);
    // R2 other offsets
    bwr(4'd0, 32'd2);
    bwr(4'd4, 32'd99);
    brd(4'd0, a, b); chk("R2 stray write leaves index", a, 2);
    brd(4'd5, a, b); chk("R2 stray offset reads 0", a, 0);
    // R4 negotiation
    bwr(4'd0, 32'd0);
    bwr(4'd1, 32'h9000_0002); brd(4'd1, a, b);
    chk("R4 accept v2", a, 32'h9000_0002); chk("R4 nocap rejects v2", b, 32'h9000_0001);
    bwr(4'd1, 32'h9000_0000); brd(4'd1, a, b); chk("R4 accept v0", a, 32'h9000_0000);
    bwr(4'd1, 32'hFFFF_FFFF); brd(4'd1, a, b); chk("R4 invalid id", a, 32'h9000_0002);
    bwr(4'd1, 32'h9000_0003); brd(4'd1, a, b); chk("R4 too new", a, 32'h9000_0002);
    m_id = 32'h9000_0002;
    // R5 enable
    bwr(4'd0, 32'd1); bwr(4'd1, 32'hFFFF_FFFF);
    chk("R5 enable+hide pins", {30'd0, hd1, en1}, 3);
    brd(4'd1, a, b); chk("R5 readback", a, 3);
    bwr(4'd1, 0); chk("R5 disable", {30'd0, hd1, en1}, 0);
    // R7 mask on nocap
    bwr(4'd0, 32'd33); bwr(4'd1, 32'd7); m_mask = 3'd7;
    brd(4'd1, a, b); chk("R7 mask", a, 7); chk("R7 nocap mask", b, 0);
    bwr(4'd1, 32'b101); m_mask = 3'b101;
    // R11/R12 interrupts
    pulse(3'b010);
    brd(4'd8, a, b); chk("R11 progress bit", a, 2);
    chk("R12 masked off", {31'd0, irq1}, 0);
    pulse(3'b001);
    chk("R12 irq on", {31'd0, irq1}, 1); chk("R12 nocap irq", {31'd0, irq2}, 0);
    bwr(4'd8, 32'b001);
    brd(4'd8, a, b); chk("R11 w1c", a, 2); chk("R12 irq off", {31'd0, irq1}, 0);
    bwr(4'd8, 32'b100, 3'b100);
    brd(4'd8, a, b); chk("R11 set wins", a, 6); chk("R12 goal irq", {31'd0, irq1}, 1);
    bwr(4'd8, 32'b111);
    brd(4'd8, a, b); chk("R11 clear all", a, 0);
    // random phase: R3 R6 R7 R8 R9 R10
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [31:0] d;
      idx = pick_idx(int'($urandom));
      d = $urandom;
      if (idx == 0 && d[0]) d = 32'h9000_0000 | 32'(d[2:1]);
      bwr(4'd0, 32'(idx));
      if ($urandom_range(1)) begin bwr(4'd1, d); model_wr(idx, d); end
      brd(4'd1, a, b);
      if (idx == 17) chk("R7 caps", a, model_rd(idx));
      else if (idx >= 1024 && idx < 1792) chk("R8 palette", a, model_rd(idx));
      else if (idx >= 1792 && idx < 1796) chk("R9 scratch", a, model_rd(idx));
      else if (idx == 40 || idx >= 1796) chk("R10 unimplemented", a, 0);
      else chk("R6 register", a, model_rd(idx));
      brd(4'd1, a, b); brd(4'd0, a, b); chk("R3 index kept", a, 32'(idx));
    end
    chk("R6 width pin", w1, m_w); chk("R6 height pin", h1, m_h); chk("R6 bpp pin", b1, m_b);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule